// File: doc/BRIEF.md
# Glitch-Free Clock Stop Gate

This block sits between a free-running source clock and a group of clock outputs. It turns the group off and back on in response to an asynchronous, active-low stop request. The request is first brought into the source-clock domain through a short flop chain. The gating enable then changes only on the falling edge of the source clock, so a stopped group always rests low and a restarted group always begins with a full-width high phase. After each restart a minimum-run window holds the group enabled for a programmed number of cycles. A stop request that arrives inside that window is held pending until the window closes.

A separate power-down input overrides both the stop request and the minimum-run window. It is synchronized in the same way. A companion output carries the source clock and is never gated. The block is reused with different parameters for each clock group, for example a two-output processor group (two sync stages, 100-cycle window) and a five-output bus group (one sync stage, 10-cycle window). The stop handshake is a plain level control, so no valid/ready interface applies.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is low, every bit of `clk_gated` is low. After reset is released with `stop_n` high and `pwr_down` low, the group produces a high pulse on every rising edge of `clk_src`, starting with the first edge after release.
- R2: `stop_n` passes through `SYNC_STAGES` flops clocked by `clk_src`. If it goes low between edges and the minimum-run window has closed, exactly `SYNC_STAGES` more high pulses appear on the following rising edges, and none after that.
- R3: While stopped, and during every low phase of `clk_src`, all bits of `clk_gated` are low.
- R4: When `stop_n` returns high, the first gated high pulse appears on rising edge number `SYNC_STAGES+1` after the change. Every gated high pulse lasts a full half period of `clk_src`.
- R5: After a restart the group delivers at least `MIN_RUN` high pulses before it can stop again. A stop that arrives during this window is held pending, and the group stops right after pulse number `MIN_RUN`.
- R6: A stop that arrives after the window has closed takes effect with the latency of R2. Random changes of `stop_n` settle to the levels that R2 and R4 predict.
- R7: A high level on `pwr_down` stops the group within `SYNC_STAGES` pulses, even inside the minimum-run window and whatever the level of `stop_n`. When it is released, the group restarts as in R4.
- R8: `clk_free` follows `clk_src` at all times, whatever the levels of `stop_n` and `pwr_down`.
- R9: All bits of `clk_gated` carry the same waveform.
- R10: Two instances with different parameters are independent: stopping one leaves the other running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock for the group; also clocks the synchronizers |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n | input | 1 | Asynchronous active-low stop request for the gated group |
| pwr_down | input | 1 | Asynchronous active-high power-down override |
| clk_gated | output | N_OUT | Gated clock outputs of the group |
| clk_free | output | 1 | Ungated companion copy of the source clock |

## Verification
The main function is exercised in four ways:
- A stop issued long after a restart isolates the pure synchronizer latency.
- A release followed at once by a new stop shows the restart edge and the exact window length.
- Stops placed halfway through the window and well after it tell a pending stop from an immediate one.
- Power-down asserted inside the window shows that the override beats the window.

Constrained-random runs of stop levels on both parameter sets then check that settled levels match the latency rules. Throughout all of these runs, every gated high pulse is timed to catch any runt pulse.

// File: rtl/clk_stop_gate_pkg.sv
`timescale 1ns/1ps
package clk_stop_gate_pkg;

  typedef enum logic {
    GATE_HALT = 1'b0,
    GATE_RUN  = 1'b1
  } gate_state_e;

  function automatic int cnt_width(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/cg_sync.sv
`timescale 1ns/1ps
module cg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= RST_VAL;
        else        pipe <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cg_minrun.sv
`timescale 1ns/1ps
module cg_minrun #(
  parameter int MIN_RUN = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic win_open
);
  localparam int            W     = clk_stop_gate_pkg::cnt_width(MIN_RUN);
  localparam logic [W-1:0]  LIMIT = W'(MIN_RUN);

  logic [W-1:0] cnt;

  // counts high pulses delivered since the enable last rose
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run_en)        cnt <= '0;
    else if (cnt != LIMIT)   cnt <= cnt + W'(1);
  end

  assign win_open = run_en && (cnt != LIMIT);
endmodule

// File: rtl/cg_enable.sv
`timescale 1ns/1ps
module cg_enable #(
  parameter int N_OUT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_want,
  output logic             run_en,
  output logic [N_OUT-1:0] clk_out
);
  import clk_stop_gate_pkg::*;

  gate_state_e state;

  // enable moves only while clk is low, so the AND below cannot chop a pulse
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) state <= GATE_HALT;
    else        state <= run_want ? GATE_RUN : GATE_HALT;
  end

  assign run_en = (state == GATE_RUN);

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
      assign clk_out[i] = clk & run_en;
    end
  endgenerate
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate #(
  parameter int N_OUT       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RUN     = 100
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic             stop_n,
  input  logic             pwr_down,
  output logic [N_OUT-1:0] clk_gated,
  output logic             clk_free
);
  logic sync_run;
  logic sync_pd;
  logic win_open;
  logic run_en;
  logic run_want;

  cg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_stop (
    .clk(clk_src), .rst_n(rst_n), .d(stop_n), .q(sync_run)
  );

  cg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pd (
    .clk(clk_src), .rst_n(rst_n), .d(pwr_down), .q(sync_pd)
  );

  cg_minrun #(.MIN_RUN(MIN_RUN)) u_minrun (
    .clk(clk_src), .rst_n(rst_n), .run_en(run_en), .win_open(win_open)
  );

  // power-down wins; an open window keeps a pending stop waiting
  assign run_want = !sync_pd && (sync_run || win_open);

  cg_enable #(.N_OUT(N_OUT)) u_enable (
    .clk(clk_src), .rst_n(rst_n), .run_want(run_want),
    .run_en(run_en), .clk_out(clk_gated)
  );

  assign clk_free = clk_src;
endmodule

// File: rtl/clk_stop_gate_chk.sv
`timescale 1ns/1ps
module clk_stop_gate_chk #(
  parameter int N_OUT = 2
) (
  input logic             clk_src,
  input logic             rst_n,
  input logic             sync_run,
  input logic             sync_pd,
  input logic             win_open,
  input logic             run_en,
  input logic [N_OUT-1:0] clk_gated
);
  assert_window_holds_R5: assert property (@(negedge clk_src) disable iff (!rst_n)
    (run_en && win_open && !sync_pd) |=> run_en);

  assert_stop_taken_R2: assert property (@(negedge clk_src) disable iff (!rst_n)
    (!sync_run && !win_open) |=> !run_en);

  assert_pd_override_R7: assert property (@(negedge clk_src) disable iff (!rst_n)
    sync_pd |=> !run_en);

  assert_restart_R4: assert property (@(negedge clk_src) disable iff (!rst_n)
    (sync_run && !sync_pd) |=> run_en);

  // high-phase value of the outputs just before a falling edge
  assert_gate_follows_R9: assert property (@(negedge clk_src) disable iff (!rst_n)
    clk_gated == {N_OUT{run_en}});
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.N_OUT(N_OUT)) u_chk (
  .clk_src(clk_src), .rst_n(rst_n), .sync_run(sync_run), .sync_pd(sync_pd),
  .win_open(win_open), .run_en(run_en), .clk_gated(clk_gated)
);

// File: tb/clk_stop_gate_tb.sv
`timescale 1ns/1ps
module clk_stop_gate_tb;
  localparam int CS = 2, CM = 100, PS = 1, PM = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pd = 1'b0;
  logic [1:0] cpu_g;
  logic [4:0] pci_g;
  logic cpu_free, pci_free;

  int tests = 0, fails = 0;
  int cpu_cnt = 0, pci_cnt = 0;
  bit done = 0, started = 0;

  clk_stop_gate #(.N_OUT(2), .SYNC_STAGES(CS), .MIN_RUN(CM)) u_dut (
    .clk_src(clk), .rst_n(rst_n), .stop_n(cpu_stop_n), .pwr_down(pd),
    .clk_gated(cpu_g), .clk_free(cpu_free));

  clk_stop_gate #(.N_OUT(5), .SYNC_STAGES(PS), .MIN_RUN(PM)) u_pci (
    .clk_src(clk), .rst_n(rst_n), .stop_n(pci_stop_n), .pwr_down(pd),
    .clk_gated(pci_g), .clk_free(pci_free));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) begin
      @(posedge clk); #2;
      if (cpu_g[0]) cpu_cnt++;
      if (pci_g[0]) pci_cnt++;
    end
  endtask

  task automatic clear();
    cpu_cnt = 0; pci_cnt = 0;
  endtask

  function automatic int exp_state(input bit lvl, input int held, input int s, input int m);
    if (!lvl) return (held >= s + m + 3) ? 0 : 2;
    return (held >= s + 2) ? 1 : 2;
  endfunction

  // sampling monitors: high phase and low phase
  always @(posedge clk) begin
    #2;
    if (started) begin
      chk(cpu_free == 1'b1 && pci_free == 1'b1, "R8 free high", int'(cpu_free), 1);
      chk(cpu_g == 2'b00 || cpu_g == 2'b11, "R9 cpu group", int'(cpu_g), 0);
      chk(pci_g == 5'b0 || pci_g == 5'b11111, "R9 pci group", int'(pci_g), 0);
    end
  end

  always @(negedge clk) begin
    #2;
    if (started) begin
      chk(cpu_free == 1'b0 && pci_free == 1'b0, "R8 free low", int'(cpu_free), 0);
      chk(cpu_g == 2'b00 && pci_g == 5'b0, "R3 low phase", int'(cpu_g) + int'(pci_g), 0);
    end
  end

  realtime c_rise, p_rise;
  bit c_seen = 0, p_seen = 0;
  always @(posedge cpu_g[0]) begin c_rise = $realtime; c_seen = 1; end
  always @(negedge cpu_g[0]) if (c_seen)
    chk(($realtime - c_rise) > 4.99, "R4 cpu pulse width ps", int'(($realtime - c_rise) * 1000), 5000);
  always @(posedge pci_g[0]) begin p_rise = $realtime; p_seen = 1; end
  always @(negedge pci_g[0]) if (p_seen)
    chk(($realtime - p_rise) > 4.99, "R4 pci pulse width ps", int'(($realtime - p_rise) * 1000), 5000);

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int first_c, first_p, e, ch, ph, len;
    bit cl, pl;
    void'($urandom(32'h5EED));

    // R1 reset state
    repeat (3) @(posedge clk);
    #2;
    chk(cpu_g == 2'b00, "R1 cpu in reset", int'(cpu_g), 0);
    chk(pci_g == 5'b0, "R1 pci in reset", int'(pci_g), 0);
    rst_n = 1'b1;
    started = 1;
    clear(); edges(200);
    chk(cpu_cnt == 200, "R1 cpu run after reset", cpu_cnt, 200);
    chk(pci_cnt == 200, "R1 pci run after reset", pci_cnt, 200);

    // R2 off latency, R10 isolation, R3 rest low
    cpu_stop_n = 1'b0; clear(); edges(20);
    chk(cpu_cnt == CS, "R2 cpu off latency", cpu_cnt, CS);
    chk(pci_cnt == 20, "R10 pci unaffected", pci_cnt, 20);
    clear(); edges(50);
    chk(cpu_cnt == 0, "R3 cpu stays low", cpu_cnt, 0);

    // R4 restart edge, R5 window with immediate re-stop
    cpu_stop_n = 1'b1; first_c = 0;
    for (int i = 1; i <= 20; i++) begin
      clear(); edges(1);
      if (cpu_cnt != 0) begin first_c = i; break; end
    end
    chk(first_c == CS + 1, "R4 cpu restart edge", first_c, CS + 1);
    cpu_stop_n = 1'b0; clear(); edges(300);
    chk(cpu_cnt + 1 == CM, "R5 cpu min run", cpu_cnt + 1, CM);

    // PCI group
    pci_stop_n = 1'b0; clear(); edges(20);
    chk(pci_cnt == PS, "R2 pci off latency", pci_cnt, PS);
    chk(cpu_cnt == 0, "R10 cpu stays stopped", cpu_cnt, 0);
    pci_stop_n = 1'b1; first_p = 0;
    for (int i = 1; i <= 20; i++) begin
      clear(); edges(1);
      if (pci_cnt != 0) begin first_p = i; break; end
    end
    chk(first_p == PS + 1, "R4 pci restart edge", first_p, PS + 1);
    pci_stop_n = 1'b0; clear(); edges(100);
    chk(pci_cnt + 1 == PM, "R5 pci min run", pci_cnt + 1, PM);

    // R5 pending stop mid-window, R6 stop after window
    cpu_stop_n = 1'b1; clear();
    while (cpu_cnt < 50) edges(1);
    cpu_stop_n = 1'b0; edges(300);
    chk(cpu_cnt == CM, "R5 cpu pending stop", cpu_cnt, CM);
    cpu_stop_n = 1'b1; clear();
    while (cpu_cnt < 150) edges(1);
    cpu_stop_n = 1'b0; edges(50);
    chk(cpu_cnt == 150 + CS, "R6 cpu late stop", cpu_cnt, 150 + CS);
    pci_stop_n = 1'b1; clear();
    while (pci_cnt < 4) edges(1);
    pci_stop_n = 1'b0; edges(50);
    chk(pci_cnt == PM, "R5 pci pending stop", pci_cnt, PM);
    pci_stop_n = 1'b1; clear();
    while (pci_cnt < 30) edges(1);
    pci_stop_n = 1'b0; edges(50);
    chk(pci_cnt == 30 + PS, "R6 pci late stop", pci_cnt, 30 + PS);

    // R7 power-down override
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1; edges(200);
    pd = 1'b1; clear(); edges(50);
    chk(cpu_cnt == CS, "R7 cpu pd latency", cpu_cnt, CS);
    chk(pci_cnt == PS, "R7 pci pd latency", pci_cnt, PS);
    clear(); edges(50);
    chk(cpu_cnt == 0 && pci_cnt == 0, "R7 pd holds low", cpu_cnt + pci_cnt, 0);
    pd = 1'b0; first_c = 0; first_p = 0;
    for (int i = 1; i <= 20; i++) begin
      clear(); edges(1);
      if (cpu_cnt != 0 && first_c == 0) first_c = i;
      if (pci_cnt != 0 && first_p == 0) first_p = i;
    end
    chk(first_c == CS + 1, "R7 cpu restart after pd", first_c, CS + 1);
    chk(first_p == PS + 1, "R7 pci restart after pd", first_p, PS + 1);
    cpu_stop_n = 1'b0; edges(200);
    cpu_stop_n = 1'b1; clear();
    while (cpu_cnt < 5) edges(1);
    pd = 1'b1; edges(50);
    chk(cpu_cnt == 5 + CS, "R7 pd beats window", cpu_cnt, 5 + CS);
    pd = 1'b0; edges(200);

    // R6 constrained random stop levels
    ch = 1000; ph = 1000;
    for (int s = 0; s < 30; s++) begin
      cl = 1'($urandom_range(0, 1));
      pl = 1'($urandom_range(0, 1));
      len = $urandom_range(1, 200);
      if (cl != cpu_stop_n) ch = 0;
      if (pl != pci_stop_n) ph = 0;
      cpu_stop_n = cl; pci_stop_n = pl;
      for (int k = 0; k < len; k++) begin
        clear(); edges(1); ch++; ph++;
      end
      e = exp_state(cl, ch, CS, CM);
      if (e != 2) chk(cpu_cnt == e, "R6 cpu random level", cpu_cnt, e);
      e = exp_state(pl, ph, PS, PM);
      if (e != 2) chk(pci_cnt == e, "R6 pci random level", pci_cnt, e);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule